// File: doc/BRIEF.md
# Up-counting timer time-base with controllable update events

This block is the counting core of a general-purpose timer. A prescaler divides the timer clock into counting ticks. A 16-bit counter climbs from zero to a reload value, wraps, and raises an update event. The update event copies the buffered prescaler and reload values into their working copies, sets a sticky interrupt flag, and, in one-shot mode, stops the counter. Software can also force an update with a strobe, and a slave-mode reset can do the same.

The control word lets software suppress update events. The counter and prescaler still restart on a strobe while events are suppressed. Software can also limit the interrupt flag to real overflows, and choose whether reload writes act at once or wait for the next update. A separate divider makes a clock-enable tick for downstream sampling logic. It runs at 1, 2 or 4 timer clocks per tick.

Register port, word select `wr_addr`/`rd_addr`: 0 = control, 1 = status, 2 = prescaler value, 3 = reload value. Control bits: 0 run, 1 one-shot, 2 reload buffered, 3 update suppress, 4 overflow-only flag source, 6:5 sampling divide.

Top module: `tmr_timebase`

## Requirements
- R1: After reset the counter output is 0, the control word reads 0x0000, and the status flag and update pulse are 0.
- R2: The prescaler makes one counting tick every P+1 clocks, where P is its working divide value. A write to address 2 reaches the working value only at an update event.
- R3: While run (control bit 0) is 1, the counter steps by one per tick. On a tick where it equals the working reload value it overflows and becomes 0. The overflow period is therefore (A+1)(P+1) clocks from a start at zero.
- R4: With control bit 2 clear, a write to address 3 sets the working reload value on that same edge. With bit 2 set, it only sets the buffered value, which is copied at the next update event. Address 3 reads back the written value.
- R5: With one-shot (control bit 1) set, an update event clears run (bit 0), and the counter holds at 0.
- R6: A `sw_upd_i` or `slv_rst_i` pulse sets the counter and prescaler phase to 0 on that edge, whatever the value of control bit 3.
- R7: With update suppress (control bit 3) set, no update event is produced. The working prescaler and reload values keep their contents and the flag is not set, though the counter still wraps at the reload value.
- R8: With control bit 4 clear, any update event sets the flag. With bit 4 set, only an overflow update sets it, and strobe-caused updates do not.
- R9: The flag (status bit 0, address 1) stays set until a status write with bit 0 = 0. A status write with bit 0 = 1 leaves it unchanged.
- R10: `upd_evt_o` is high for exactly the one clock following each update-event edge. No pulse appears without an update event.
- R11: `smp_tick_o` is high on every clock when control bits 6:5 = 00, on one clock in 2 for 01, and on one clock in 4 for 10. The reserved value 11 acts like 10.
- R12: Control bits 15:7 read as 0 whatever is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select for writes |
| wr_data | input | 16 | Write data |
| rd_addr | input | 2 | Register select for reads |
| rd_data | output | 16 | Combinational read data |
| sw_upd_i | input | 1 | Software update-generation strobe |
| slv_rst_i | input | 1 | Slave-mode reset strobe |
| cnt_o | output | 16 | Counter value |
| upd_evt_o | output | 1 | Update-event pulse |
| upd_flag_o | output | 1 | Sticky update interrupt flag |
| smp_tick_o | output | 1 | Sampling clock enable |

## Verification
The bench runs all sixteen settings of one-shot, reload buffering, update suppress and overflow-only. In each it issues a software strobe, times the overflow pulses against (A+1)(P+1), and checks the counter value and the flag at a chosen stop edge. A design that let a suppressed strobe load the shadows would count with the wrong period. A design whose one-shot mode failed to clear run would produce an extra pulse that the scoreboard rejects. A strobe issued while the counter runs with updates suppressed must zero the counter without a pulse or a flag. A slave reset issued with overflow-only set must pulse without setting the flag; a design that missed either would show a stray counter value or flag. Status writes of 1 must leave the flag set, and a reserved sampling divide must behave like divide-by-4.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int CTRL_BITS = 7;

    typedef enum logic [1:0] {
        SEL_CTRL = 2'd0,
        SEL_STAT = 2'd1,
        SEL_PSC  = 2'd2,
        SEL_RLD  = 2'd3
    } reg_sel_e;

    typedef enum logic [1:0] {
        SMP_DIV1 = 2'd0,
        SMP_DIV2 = 2'd1,
        SMP_DIV4 = 2'd2,
        SMP_RSVD = 2'd3
    } smp_div_e;

    typedef struct packed {
        smp_div_e smp_div;   // 6:5
        logic     ovf_only;  // 4
        logic     upd_off;   // 3
        logic     buf_rld;   // 2
        logic     one_shot;  // 1
        logic     run;       // 0
    } ctrl_t;

    function automatic logic [15:0] ctrl_word(input ctrl_t c);
        return {{(16-CTRL_BITS){1'b0}}, c};
    endfunction

endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         run,
    input  logic         reinit,
    input  logic         uev,
    input  logic [W-1:0] psc_pre,
    output logic         tick,
    output logic [W-1:0] psc_sh,
    output logic [W-1:0] psc_cnt
);
    assign tick = run && (psc_cnt == psc_sh);

    always_ff @(posedge clk) begin
        if (rst) begin
            psc_cnt <= '0;
            psc_sh  <= '0;
        end else begin
            if (uev)
                psc_sh <= psc_pre;
            if (reinit)
                psc_cnt <= '0;
            else if (run)
                psc_cnt <= tick ? '0 : psc_cnt + 1'b1;
        end
    end

    // R2: between ticks the phase advances by exactly one
    a_r2_phase_step: assert property (@(posedge clk) disable iff (rst)
        (run && !reinit && !tick) |=> (psc_cnt == $past(psc_cnt) + 1'b1));

endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic         reinit,
    input  logic         uev,
    input  logic         wr_rld,
    input  logic         buf_rld,
    input  logic [W-1:0] rld_data,
    output logic [W-1:0] cnt,
    output logic         ovf,
    output logic [W-1:0] arr_act,
    output logic [W-1:0] arr_pre
);
    localparam logic [W-1:0] RLD_RST = '1;

    assign ovf = tick && !reinit && (cnt == arr_act);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt     <= '0;
            arr_act <= RLD_RST;
            arr_pre <= RLD_RST;
        end else begin
            if (reinit)
                cnt <= '0;
            else if (tick)
                cnt <= (cnt == arr_act) ? '0 : cnt + 1'b1;

            if (wr_rld)
                arr_pre <= rld_data;

            if (wr_rld && !buf_rld)
                arr_act <= rld_data;
            else if (uev)
                arr_act <= arr_pre;
        end
    end

    // R3: an overflow tick leaves the counter at zero
    a_r3_wrap_zero: assert property (@(posedge clk) disable iff (rst)
        ovf |=> (cnt == '0));

    // R4: an unbuffered reload write is live on the next cycle
    a_r4_direct_rld: assert property (@(posedge clk) disable iff (rst)
        (wr_rld && !buf_rld) |=> (arr_act == $past(rld_data)));

endmodule

// File: rtl/tmr_smpclk.sv
module tmr_smpclk
    import tmr_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  smp_div_e div,
    output logic     tick
);
    logic [1:0] phase;

    always_ff @(posedge clk) begin
        if (rst) phase <= '0;
        else     phase <= phase + 2'd1;
    end

    always_comb begin
        unique case (div)
            SMP_DIV1: tick = 1'b1;
            SMP_DIV2: tick = phase[0];
            default:  tick = &phase;
        endcase
    end

    // R11: in divide-by-4 the enable never appears on two adjacent clocks
    a_r11_div4_gap: assert property (@(posedge clk) disable iff (rst)
        (tick && div == SMP_DIV4 && $stable(div)) |=> !tick || (div != SMP_DIV4));

endmodule

// File: rtl/tmr_timebase.sv
module tmr_timebase
    import tmr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [CNT_W-1:0] wr_data,
    input  logic [1:0]       rd_addr,
    output logic [CNT_W-1:0] rd_data,
    input  logic             sw_upd_i,
    input  logic             slv_rst_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             upd_evt_o,
    output logic             upd_flag_o,
    output logic             smp_tick_o
);
    ctrl_t            ctrl_q;
    logic [CNT_W-1:0] psc_pre, psc_sh, psc_cnt, arr_act, arr_pre;
    logic             tick, ovf, reinit, uev, flag_set;
    logic             wr_ctrl, wr_stat, wr_psc, wr_rld;

    assign wr_ctrl  = wr_en && (reg_sel_e'(wr_addr) == SEL_CTRL);
    assign wr_stat  = wr_en && (reg_sel_e'(wr_addr) == SEL_STAT);
    assign wr_psc   = wr_en && (reg_sel_e'(wr_addr) == SEL_PSC);
    assign wr_rld   = wr_en && (reg_sel_e'(wr_addr) == SEL_RLD);

    assign reinit   = sw_upd_i || slv_rst_i;
    assign uev      = !ctrl_q.upd_off && (ovf || reinit);
    assign flag_set = uev && (ovf || !ctrl_q.ovf_only);

    tmr_prescaler #(.W(CNT_W)) u_psc (
        .clk     (clk),
        .rst     (rst),
        .run     (ctrl_q.run),
        .reinit  (reinit),
        .uev     (uev),
        .psc_pre (psc_pre),
        .tick    (tick),
        .psc_sh  (psc_sh),
        .psc_cnt (psc_cnt)
    );

    tmr_counter #(.W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .reinit   (reinit),
        .uev      (uev),
        .wr_rld   (wr_rld),
        .buf_rld  (ctrl_q.buf_rld),
        .rld_data (wr_data),
        .cnt      (cnt_o),
        .ovf      (ovf),
        .arr_act  (arr_act),
        .arr_pre  (arr_pre)
    );

    tmr_smpclk u_smp (
        .clk  (clk),
        .rst  (rst),
        .div  (ctrl_q.smp_div),
        .tick (smp_tick_o)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q     <= '0;
            psc_pre    <= '0;
            upd_flag_o <= 1'b0;
            upd_evt_o  <= 1'b0;
        end else begin
            if (wr_ctrl)
                ctrl_q <= ctrl_t'(wr_data[CTRL_BITS-1:0]);
            if (uev && ctrl_q.one_shot)
                ctrl_q.run <= 1'b0;
            if (wr_psc)
                psc_pre <= wr_data;
            if (flag_set)
                upd_flag_o <= 1'b1;
            else if (wr_stat && !wr_data[0])
                upd_flag_o <= 1'b0;
            upd_evt_o <= uev;
        end
    end

    always_comb begin
        unique case (reg_sel_e'(rd_addr))
            SEL_CTRL: rd_data = CNT_W'(ctrl_word(ctrl_q));
            SEL_STAT: rd_data = {{(CNT_W-1){1'b0}}, upd_flag_o};
            SEL_PSC:  rd_data = psc_pre;
            default:  rd_data = arr_pre;
        endcase
    end

    // R5: one-shot update stops the counter
    a_r5_one_shot_stop: assert property (@(posedge clk) disable iff (rst)
        (uev && ctrl_q.one_shot) |=> !ctrl_q.run);

    // R6: strobes restart counter and prescaler phase
    a_r6_reinit_zero: assert property (@(posedge clk) disable iff (rst)
        reinit |=> (cnt_o == '0 && psc_cnt == '0));

    // R7: suppressed updates leave the shadow prescaler alone
    a_r7_shadow_hold: assert property (@(posedge clk) disable iff (rst)
        ctrl_q.upd_off |=> $stable(psc_sh));

    // R8: overflow-only source never sets the flag without an overflow
    a_r8_ovf_only_flag: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q.ovf_only && !ovf && !upd_flag_o) |=> !upd_flag_o);

    // R10: the event pulse follows an update condition
    a_r10_pulse_src: assert property (@(posedge clk) disable iff (rst)
        $rose(upd_evt_o) |-> $past(!ctrl_q.upd_off));

endmodule

// File: tb/tmr_timebase_tb.sv
module tmr_timebase_tb_top;
    timeunit 1ns;
    timeprecision 1ps;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [1:0]  rd_addr = '0;
    logic [15:0] rd_data;
    logic        sw_upd = 1'b0;
    logic        slv_rst = 1'b0;
    logic [15:0] cnt_o;
    logic        upd_evt_o, upd_flag_o, smp_tick_o;

    int cyc = 0;
    int errs = 0;
    int checks = 0;
    int last_edge = 0;
    int exp_q[$];
    bit done = 1'b0;

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    tmr_timebase dut_i (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .rd_addr    (rd_addr),
        .rd_data    (rd_data),
        .sw_upd_i   (sw_upd),
        .slv_rst_i  (slv_rst),
        .cnt_o      (cnt_o),
        .upd_evt_o  (upd_evt_o),
        .upd_flag_o (upd_flag_o),
        .smp_tick_o (smp_tick_o)
    );

    // scoreboard monitor: each pulse must match the oldest expected edge (R10)
    always @(negedge clk) begin
        if (!rst && upd_evt_o && !done) begin
            checks++;
            if (exp_q.size() == 0) begin
                errs++;
                $display("FAIL R10 update pulse at edge %0d, expected none", cyc);
            end else begin
                int e;
                e = exp_q.pop_front();
                if (e != cyc) begin
                    errs++;
                    $display("FAIL R10 update pulse at edge %0d, expected %0d", cyc, e);
                end
            end
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr_reg(input int a, input int d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a[1:0]; wr_data = d[15:0];
        last_edge = cyc + 1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic strobe(input bit slv, input bit expect_evt);
        @(negedge clk);
        if (slv) slv_rst = 1'b1; else sw_upd = 1'b1;
        if (expect_evt) exp_q.push_back(cyc + 1);
        @(negedge clk);
        sw_upd = 1'b0; slv_rst = 1'b0;
    endtask

    task automatic rd_chk(input string req, input int a, input int exp);
        rd_addr = a[1:0];
        #1;
        chk(req, rd_data, exp);
    endtask

    task automatic wait_until(input int c);
        while (cyc < c) @(negedge clk);
    endtask

    // known state: prescaler 0, reload 7, flag clear
    task automatic baseline();
        wr_reg(0, 0);
        wr_reg(2, 0);
        wr_reg(3, 7);
        strobe(1'b0, 1'b1);
        wr_reg(1, 0);
    endtask

    task automatic run_combo(input bit os, input bit bf, input bit uo, input bit oo);
        int m, p, a, t, k;
        m = (int'(oo) << 4) | (int'(uo) << 3) | (int'(bf) << 2) | (int'(os) << 1);
        baseline();
        wr_reg(0, m);
        wr_reg(2, 1);
        wr_reg(3, 3);
        strobe(1'b0, !uo);
        chk("R8 flag after software strobe", upd_flag_o, int'(!uo && !oo));
        chk("R6 counter after software strobe", cnt_o, 0);
        rd_chk("R4 reload readback", 3, 3);
        wr_reg(1, 0);
        chk("R9 flag cleared by status write 0", upd_flag_o, 0);
        p = uo ? 0 : 1;
        a = (bf && uo) ? 7 : 3;
        t = (a + 1) * (p + 1);
        wr_reg(0, m | 1);
        k = last_edge;
        if (!uo) exp_q.push_back(k + t);
        if (!uo && !os) exp_q.push_back(k + 2 * t);
        wait_until(k + t + 1);
        rd_chk("R5 run bit after first overflow", 0, m | ((os && !uo) ? 0 : 1));
        wait_until(k + 2 * t - 1);
        wr_reg(0, m);
        chk("R3 counter at stop edge", cnt_o, (os && !uo) ? 0 : ((p == 0) ? 1 : 0));
        chk("R7 flag after overflows", upd_flag_o, int'(!uo));
        wr_reg(1, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            errs++; checks++;
            $display("FAIL watchdog expired, expected completion");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        int k, n;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        chk("R1 counter", cnt_o, 0);
        chk("R1 flag", upd_flag_o, 0);
        chk("R1 pulse", upd_evt_o, 0);
        rd_chk("R1 control", 0, 0);

        for (int i = 0; i < 16; i++)
            run_combo(i[0], i[1], i[2], i[3]);

        // R6, R7: strobe while running with updates suppressed
        baseline();
        wr_reg(3, 200);
        wr_reg(0, 16'h0009);
        k = last_edge;
        wait_until(k + 10);
        chk("R3 counter after ten ticks", cnt_o, 10);
        strobe(1'b0, 1'b0);
        chk("R6 counter zeroed under suppress", cnt_o, 0);
        chk("R7 no flag under suppress", upd_flag_o, 0);

        // R8: slave reset with overflow-only source
        wr_reg(0, 16'h0011);
        strobe(1'b1, 1'b1);
        chk("R6 counter after slave reset", cnt_o, 0);
        chk("R8 no flag from slave reset", upd_flag_o, 0);
        wr_reg(0, 0);
        strobe(1'b1, 1'b1);
        chk("R8 flag from slave reset", upd_flag_o, 1);
        wr_reg(1, 1);
        chk("R9 status write 1 keeps flag", upd_flag_o, 1);
        wr_reg(1, 0);
        chk("R9 status write 0 clears flag", upd_flag_o, 0);

        // R11: sampling enable rates
        for (int d = 0; d < 4; d++) begin
            wr_reg(0, d << 5);
            n = 0;
            for (int c = 0; c < 8; c++) begin
                @(negedge clk);
                if (smp_tick_o) n++;
            end
            chk("R11 sampling ticks in 8 clocks", n, (d == 0) ? 8 : (d == 1) ? 4 : 2);
        end

        // R12: reserved control bits
        wr_reg(0, 16'hFFFF);
        rd_chk("R12 reserved bits read 0", 0, 16'h007F);
        wr_reg(0, 0);

        repeat (4) @(negedge clk);
        chk("R10 all expected pulses seen", exp_q.size(), 0);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule